// File: doc/BRIEF.md
# ADC Engine Register Block

This block is the 32-bit register file of one analog-to-digital converter engine with sixteen channels, two channels to a word. Software reaches it over a simple word-aligned bus: an address, a write enable with write data, and a read strobe whose data comes back one cycle later. Inside sit the engine control word, the interrupt control word, the detect and clock control words, eight sample words, sixteen bound words, sixteen hysteresis words, an interrupt source field and a trim field.

No converter front end is attached. Instead a synthetic sampler moves each sample word forward every time it is read. The lower channel steps by 5 and the upper channel by 7, both modulo 1024. On the same read, the two values held before the step are compared with their window limits. A value outside its window latches a per-word interrupt bit, and this bit drives the interrupt output until software clears it.

Top module: `adc_engine_regs`

## Requirements
- R1: After reset, the detect control word (0x08) and the clock control word (0x0C) read 0x0000000F. Every other register reads zero, including all sample, bound and hysteresis words, and `irqOut` is low.
- R2: Register offsets are as follows. Control 0x00, interrupt control 0x04, detect control 0x08, clock control 0x0C, sample words 0x10–0x2C, bound words 0x30–0x6C, hysteresis words 0x70–0xAC, interrupt source 0xC0, trim 0xC4. The word index is (address − base) >> 2. Detect and clock control store all 32 bits. Reads of any other offset, or of an address with bits [1:0] nonzero, return zero. Writes to such addresses change nothing.
- R3: `busRdData` takes the addressed value on the clock edge that samples the rising read strobe. It holds that value until the next read.
- R4: A write to a sample word keeps only bits [9:0] (lower channel) and bits [25:16] (upper channel). All other bits read zero.
- R5: A sample read returns the word as it was before the read. At that same edge the lower field grows by 5 and the upper field by 7, each modulo 1024.
- R6: Bound word 2k holds the window of the lower channel of sample word k, and bound word 2k+1 holds the window of its upper channel. The low limit is in bits [9:0] and the high limit in bits [25:16]. Bound writes keep only those two fields.
- R7: On a read of sample word k, bit k of interrupt control is set if either channel value held before the step is below its low limit or above its high limit. The bit is set at the same edge as the step.
- R8: `irqOut` is the OR of interrupt control bits [7:0]. A set bit stays set until software writes it clear. A write to 0x04 stores all 32 bits, and bits above 7 do not drive `irqOut`.
- R9: A write to control (0x00) stores bit 8 equal to written bit 0 and stores bit 5 as zero. All other bits are stored as written.
- R10: Hysteresis writes keep bit 31 plus bits [25:16] and [9:0]. Interrupt source writes keep bits [15:0]. Trim writes keep bits [3:0].
- R11: A read strobe held high for several cycles advances the sample word and runs the window check only once. A new read needs the strobe to go low and rise again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Byte address of the access |
| busWrEn | input | 1 | Write enable, one write per high cycle |
| busWrData | input | 32 | Write data |
| busRdEn | input | 1 | Read strobe, acted on at its rising edge |
| busRdData | output | 32 | Registered read data |
| irqOut | output | 1 | Interrupt, OR of interrupt control bits [7:0] |

## Verification
The assertions take for granted that a write and a read never hit the same sample word or the interrupt control word in the same cycle. They also assume the bus holds address and data stable while a strobe is high. Only under these conditions are the step and the latched interrupt bit separate, observable events. The stimulus never issues a write and a read in the same cycle. It places every read strobe on its own rising edge, except in the one test that holds the strobe high on purpose to check the single step. The bound values are chosen so that each window test lands on an exact edge of its limit: inside at the limit, then one step past it.

// File: rtl/adc_eng_pkg.sv
package adc_eng_pkg;

  typedef enum logic [3:0] {
    K_NONE, K_CTRL, K_IRQ, K_DET, K_CLK,
    K_SAMP, K_BND, K_HYST, K_SRC, K_TRIM
  } regKind_e;

  localparam int IDX_W = 4;

  // strobes from decode/control to the datapath
  typedef struct packed {
    regKind_e         kind;
    logic [IDX_W-1:0] idx;
    logic             wrStb;
    logic             rdStb;
  } busOp_t;

  localparam int OFS_CTRL = 'h00;
  localparam int OFS_IRQ  = 'h04;
  localparam int OFS_DET  = 'h08;
  localparam int OFS_CLK  = 'h0C;
  localparam int OFS_SAMP = 'h10;
  localparam int OFS_BND  = 'h30;
  localparam int OFS_HYST = 'h70;
  localparam int OFS_SRC  = 'hC0;
  localparam int OFS_TRIM = 'hC4;

  localparam int HI_LSB       = 16;
  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_AC_BIT  = 5;
  localparam int CTRL_RDY_BIT = 8;
  localparam int HYST_EN_BIT  = 31;
  localparam int SRC_W        = 16;
  localparam int TRIM_W       = 4;
  localparam int IRQ_OUT_BITS = 8;
  localparam logic [31:0] DET_RST = 32'h0000_000F;
  localparam logic [31:0] CLK_RST = 32'h0000_000F;

endpackage

// File: rtl/adc_eng_ctrl.sv
module adc_eng_ctrl
  import adc_eng_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_PAIRS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output busOp_t            op
);

  localparam int NUM_BND = 2 * NUM_PAIRS;
  localparam logic [ADDR_W-1:0] SAMP_LO = ADDR_W'(OFS_SAMP);
  localparam logic [ADDR_W-1:0] SAMP_HI = ADDR_W'(OFS_SAMP + 4 * NUM_PAIRS);
  localparam logic [ADDR_W-1:0] BND_LO  = ADDR_W'(OFS_BND);
  localparam logic [ADDR_W-1:0] BND_HI  = ADDR_W'(OFS_BND + 4 * NUM_BND);
  localparam logic [ADDR_W-1:0] HYST_LO = ADDR_W'(OFS_HYST);
  localparam logic [ADDR_W-1:0] HYST_HI = ADDR_W'(OFS_HYST + 4 * NUM_BND);

  logic rdEnQ;
  regKind_e kind;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (!rstN) rdEnQ <= 1'b0;
    else       rdEnQ <= busRdEn;
  end

  always_comb begin
    kind = K_NONE;
    idx  = '0;
    if (busAddr[1:0] == 2'b00) begin
      if (busAddr == ADDR_W'(OFS_CTRL))      kind = K_CTRL;
      else if (busAddr == ADDR_W'(OFS_IRQ))  kind = K_IRQ;
      else if (busAddr == ADDR_W'(OFS_DET))  kind = K_DET;
      else if (busAddr == ADDR_W'(OFS_CLK))  kind = K_CLK;
      else if (busAddr == ADDR_W'(OFS_SRC))  kind = K_SRC;
      else if (busAddr == ADDR_W'(OFS_TRIM)) kind = K_TRIM;
      else if (busAddr >= SAMP_LO && busAddr < SAMP_HI) begin
        kind = K_SAMP;
        idx  = IDX_W'((busAddr - SAMP_LO) >> 2);
      end else if (busAddr >= BND_LO && busAddr < BND_HI) begin
        kind = K_BND;
        idx  = IDX_W'((busAddr - BND_LO) >> 2);
      end else if (busAddr >= HYST_LO && busAddr < HYST_HI) begin
        kind = K_HYST;
        idx  = IDX_W'((busAddr - HYST_LO) >> 2);
      end
    end
  end

  assign op.kind  = kind;
  assign op.idx   = idx;
  assign op.wrStb = busWrEn;
  assign op.rdStb = busRdEn & ~rdEnQ;

  // R11: a held strobe yields a single read action
  assert_single_read_R11: assert property (@(posedge clk) disable iff (!rstN)
    op.rdStb |=> !op.rdStb);

endmodule

// File: rtl/adc_eng_data.sv
module adc_eng_data
  import adc_eng_pkg::*;
#(
  parameter int NUM_PAIRS = 8,
  parameter int VAL_W     = 10,
  parameter int LO_STEP   = 5,
  parameter int HI_STEP   = 7
) (
  input  logic        clk,
  input  logic        rstN,
  input  busOp_t      op,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  output logic        irqOut
);

  localparam int NUM_BND = 2 * NUM_PAIRS;
  localparam logic [VAL_W-1:0] LO_INC = VAL_W'(LO_STEP);
  localparam logic [VAL_W-1:0] HI_INC = VAL_W'(HI_STEP);

  function automatic logic [31:0] packPair(input logic [VAL_W-1:0] lo,
                                           input logic [VAL_W-1:0] hi);
    logic [31:0] w;
    w = '0;
    w[VAL_W-1:0] = lo;
    w[HI_LSB +: VAL_W] = hi;
    return w;
  endfunction

  logic [31:0] ctrlReg, irqReg, detReg, clkReg, rdDataQ;
  logic [SRC_W-1:0]  srcReg;
  logic [TRIM_W-1:0] trimReg;
  logic [VAL_W-1:0]  sampLo [NUM_PAIRS];
  logic [VAL_W-1:0]  sampHi [NUM_PAIRS];
  logic [VAL_W-1:0]  bndLo  [NUM_BND];
  logic [VAL_W-1:0]  bndHi  [NUM_BND];
  logic [VAL_W-1:0]  hystLo [NUM_BND];
  logic [VAL_W-1:0]  hystHi [NUM_BND];
  logic [NUM_BND-1:0] hystEn;

  logic [NUM_PAIRS-1:0] rdHit, sampWr, breach, setMask;
  logic [VAL_W-1:0] wLo, wHi;
  logic irqWr;

  assign wLo   = busWrData[VAL_W-1:0];
  assign wHi   = busWrData[HI_LSB +: VAL_W];
  assign irqWr = op.wrStb && op.kind == K_IRQ;

  // per-word hit decode and window check
  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
    assign rdHit[k]  = op.rdStb && op.kind == K_SAMP && op.idx == IDX_W'(k);
    assign sampWr[k] = op.wrStb && op.kind == K_SAMP && op.idx == IDX_W'(k);
    assign breach[k] = (sampLo[k] < bndLo[2*k])   || (sampLo[k] > bndHi[2*k]) ||
                       (sampHi[k] < bndLo[2*k+1]) || (sampHi[k] > bndHi[2*k+1]);
  end
  assign setMask = rdHit & breach;

  // scalar registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      irqReg  <= '0;
      detReg  <= DET_RST;
      clkReg  <= CLK_RST;
      srcReg  <= '0;
      trimReg <= '0;
    end else begin
      if (op.wrStb) begin
        case (op.kind)
          K_CTRL: begin
            ctrlReg <= busWrData;
            ctrlReg[CTRL_RDY_BIT] <= busWrData[CTRL_EN_BIT];
            ctrlReg[CTRL_AC_BIT]  <= 1'b0;
          end
          K_DET:  detReg  <= busWrData;
          K_CLK:  clkReg  <= busWrData;
          K_SRC:  srcReg  <= busWrData[SRC_W-1:0];
          K_TRIM: trimReg <= busWrData[TRIM_W-1:0];
          default: ;
        endcase
      end
      if (irqWr) irqReg <= busWrData;
      else       irqReg <= irqReg | 32'(setMask);
    end
  end

  // sample words: write wins over the read side effect
  always_ff @(posedge clk) begin
    for (int k = 0; k < NUM_PAIRS; k++) begin
      if (!rstN) begin
        sampLo[k] <= '0;
        sampHi[k] <= '0;
      end else if (sampWr[k]) begin
        sampLo[k] <= wLo;
        sampHi[k] <= wHi;
      end else if (rdHit[k]) begin
        sampLo[k] <= sampLo[k] + LO_INC;
        sampHi[k] <= sampHi[k] + HI_INC;
      end
    end
  end

  // bound and hysteresis words
  always_ff @(posedge clk) begin
    for (int j = 0; j < NUM_BND; j++) begin
      if (!rstN) begin
        bndLo[j]  <= '0;
        bndHi[j]  <= '0;
        hystLo[j] <= '0;
        hystHi[j] <= '0;
        hystEn[j] <= 1'b0;
      end else if (op.wrStb && op.idx == IDX_W'(j)) begin
        if (op.kind == K_BND) begin
          bndLo[j] <= wLo;
          bndHi[j] <= wHi;
        end
        if (op.kind == K_HYST) begin
          hystLo[j] <= wLo;
          hystHi[j] <= wHi;
          hystEn[j] <= busWrData[HYST_EN_BIT];
        end
      end
    end
  end

  // read mux: values before this edge's side effects
  logic [31:0] rdMux;
  always_comb begin
    rdMux = '0;
    case (op.kind)
      K_CTRL: rdMux = ctrlReg;
      K_IRQ:  rdMux = irqReg;
      K_DET:  rdMux = detReg;
      K_CLK:  rdMux = clkReg;
      K_SRC:  rdMux = 32'(srcReg);
      K_TRIM: rdMux = 32'(trimReg);
      K_SAMP:
        for (int k = 0; k < NUM_PAIRS; k++)
          if (op.idx == IDX_W'(k)) rdMux = packPair(sampLo[k], sampHi[k]);
      K_BND:
        for (int j = 0; j < NUM_BND; j++)
          if (op.idx == IDX_W'(j)) rdMux = packPair(bndLo[j], bndHi[j]);
      K_HYST:
        for (int j = 0; j < NUM_BND; j++)
          if (op.idx == IDX_W'(j)) begin
            rdMux = packPair(hystLo[j], hystHi[j]);
            rdMux[HYST_EN_BIT] = hystEn[j];
          end
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rdDataQ <= '0;
    else if (op.rdStb)  rdDataQ <= rdMux;
  end

  assign busRdData = rdDataQ;
  assign irqOut    = |irqReg[IRQ_OUT_BITS-1:0];

  // R3: read data only moves on a read strobe
  assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !op.rdStb |=> $stable(rdDataQ));

  // R2: unmapped reads return zero
  assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (op.rdStb && op.kind == K_NONE) |=> rdDataQ == '0);

  // R9: init flag follows enable, auto-compensation cleared
  assert_ctrl_init_R9: assert property (@(posedge clk) disable iff (!rstN)
    (op.wrStb && op.kind == K_CTRL) |=>
      (ctrlReg[CTRL_RDY_BIT] == $past(busWrData[CTRL_EN_BIT])) && !ctrlReg[CTRL_AC_BIT]);

  // R8: status bits are sticky without a software write
  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    !irqWr |=> (irqReg & $past(irqReg)) == $past(irqReg));

  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_chk
    // R5: sample advances by the fixed steps on a read
    assert_step_R5: assert property (@(posedge clk) disable iff (!rstN)
      (rdHit[k] && !sampWr[k]) |=>
        (sampLo[k] == $past(sampLo[k]) + LO_INC) && (sampHi[k] == $past(sampHi[k]) + HI_INC));
    // R11: no read, no write, no change
    assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rstN)
      (!rdHit[k] && !sampWr[k]) |=> $stable(sampLo[k]) && $stable(sampHi[k]));
    // R7: out-of-window read latches the status bit
    assert_breach_latch_R7: assert property (@(posedge clk) disable iff (!rstN)
      (rdHit[k] && breach[k] && !irqWr) |=> irqReg[k]);
  end

endmodule

// File: rtl/adc_engine_regs.sv
module adc_engine_regs
  import adc_eng_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_PAIRS = 8,
  parameter int VAL_W     = 10,
  parameter int LO_STEP   = 5,
  parameter int HI_STEP   = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  input  logic              busRdEn,
  output logic [31:0]       busRdData,
  output logic              irqOut
);

  busOp_t op;

  adc_eng_ctrl #(
    .ADDR_W(ADDR_W), .NUM_PAIRS(NUM_PAIRS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .op(op)
  );

  adc_eng_data #(
    .NUM_PAIRS(NUM_PAIRS), .VAL_W(VAL_W),
    .LO_STEP(LO_STEP), .HI_STEP(HI_STEP)
  ) uData (
    .clk(clk), .rstN(rstN), .op(op), .busWrData(busWrData),
    .busRdData(busRdData), .irqOut(irqOut)
  );

endmodule

// File: tb/tb_adc_engine_regs.sv
module tb_adc_engine_regs;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [31:0] busRdData;
  logic        irqOut;

  always #10 clk = ~clk; // 50 MHz

  adc_engine_regs dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .irqOut(irqOut)
  );

  int nChecks = 0;
  int nFail   = 0;

  typedef enum logic [1:0] {OP_WR, OP_RD, OP_IRQ, OP_HOLD} vop_e;
  typedef struct packed {
    vop_e        op;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 62;
  localparam vec_t VECS [NVEC] = '{
    '{OP_RD,  8'h00, 32'h0, 32'h0, 8'd1},           // R1 control
    '{OP_RD,  8'h04, 32'h0, 32'h0, 8'd1},           // R1 irq control
    '{OP_RD,  8'h08, 32'h0, 32'h0000000F, 8'd1},    // R1 detect
    '{OP_RD,  8'h0C, 32'h0, 32'h0000000F, 8'd1},    // R1 clock
    '{OP_RD,  8'h30, 32'h0, 32'h0, 8'd1},           // R1 bound
    '{OP_RD,  8'h70, 32'h0, 32'h0, 8'd1},           // R1 hysteresis
    '{OP_RD,  8'hC0, 32'h0, 32'h0, 8'd1},           // R1 source
    '{OP_RD,  8'hC4, 32'h0, 32'h0, 8'd1},           // R1 trim
    '{OP_RD,  8'h10, 32'h0, 32'h0, 8'd1},           // R1 sample 0, in window 0..0
    '{OP_RD,  8'h10, 32'h0, 32'h00070005, 8'd5},    // R5 stepped once
    '{OP_IRQ, 8'h00, 32'h0, 32'h1, 8'd7},           // R7 5,7 above limit 0
    '{OP_RD,  8'h04, 32'h0, 32'h1, 8'd7},           // R7 bit 0
    '{OP_WR,  8'h04, 32'h0, 32'h0, 8'd8},
    '{OP_IRQ, 8'h00, 32'h0, 32'h0, 8'd8},           // R8 cleared
    '{OP_WR,  8'h00, 32'hFFFF002F, 32'h0, 8'd9},
    '{OP_RD,  8'h00, 32'h0, 32'hFFFF010F, 8'd9},    // R9 init set, autocomp cleared
    '{OP_WR,  8'h00, 32'h00000120, 32'h0, 8'd9},
    '{OP_RD,  8'h00, 32'h0, 32'h0, 8'd9},           // R9 init follows enable=0
    '{OP_WR,  8'h70, 32'hFFFFFFFF, 32'h0, 8'd10},
    '{OP_RD,  8'h70, 32'h0, 32'h83FF03FF, 8'd10},   // R10 hysteresis mask
    '{OP_WR,  8'hC0, 32'hFFFFFFFF, 32'h0, 8'd10},
    '{OP_RD,  8'hC0, 32'h0, 32'h0000FFFF, 8'd10},   // R10 source mask
    '{OP_WR,  8'hC4, 32'hFFFFFFFF, 32'h0, 8'd10},
    '{OP_RD,  8'hC4, 32'h0, 32'h0000000F, 8'd10},   // R10 trim mask
    '{OP_WR,  8'h08, 32'h12345678, 32'h0, 8'd2},
    '{OP_RD,  8'h08, 32'h0, 32'h12345678, 8'd2},    // R2 detect full width
    '{OP_WR,  8'h0C, 32'hA5A5A5A5, 32'h0, 8'd2},
    '{OP_RD,  8'h0C, 32'h0, 32'hA5A5A5A5, 8'd2},    // R2 clock full width
    '{OP_WR,  8'hB0, 32'hFFFFFFFF, 32'h0, 8'd2},
    '{OP_RD,  8'hB0, 32'h0, 32'h0, 8'd2},           // R2 unmapped reads zero
    '{OP_WR,  8'h31, 32'hFFFFFFFF, 32'h0, 8'd2},
    '{OP_RD,  8'h30, 32'h0, 32'h0, 8'd2},           // R2 unaligned write ignored
    '{OP_RD,  8'hC8, 32'h0, 32'h0, 8'd2},           // R2 unmapped
    '{OP_WR,  8'h40, 32'h03FF0000, 32'h0, 8'd6},
    '{OP_WR,  8'h44, 32'hFFFF0000, 32'h0, 8'd6},
    '{OP_RD,  8'h44, 32'h0, 32'h03FF0000, 8'd6},    // R6 bound mask
    '{OP_WR,  8'h18, 32'hFFFFFFFF, 32'h0, 8'd4},
    '{OP_RD,  8'h18, 32'h0, 32'h03FF03FF, 8'd4},    // R4 sample mask
    '{OP_RD,  8'h18, 32'h0, 32'h00060004, 8'd5},    // R5 wrap modulo 1024
    '{OP_IRQ, 8'h00, 32'h0, 32'h0, 8'd6},           // R6 full window, no breach
    '{OP_HOLD,8'h00, 32'h0, 32'h00060004, 8'd3},    // R3 data held
    '{OP_WR,  8'h1C, 32'h00C80064, 32'h0, 8'd7},
    '{OP_WR,  8'h48, 32'h00680064, 32'h0, 8'd7},
    '{OP_WR,  8'h4C, 32'h00CD0000, 32'h0, 8'd7},
    '{OP_RD,  8'h1C, 32'h0, 32'h00C80064, 8'd7},    // R7 100 at low limit
    '{OP_IRQ, 8'h00, 32'h0, 32'h0, 8'd7},           // R7 inside window
    '{OP_RD,  8'h1C, 32'h0, 32'h00CF0069, 8'd7},    // R7 105 above 104
    '{OP_IRQ, 8'h00, 32'h0, 32'h1, 8'd7},
    '{OP_RD,  8'h04, 32'h0, 32'h00000008, 8'd7},    // R7 bit 3
    '{OP_WR,  8'h50, 32'h03FF0000, 32'h0, 8'd7},
    '{OP_WR,  8'h54, 32'h03FF0001, 32'h0, 8'd7},
    '{OP_RD,  8'h20, 32'h0, 32'h0, 8'd7},           // R7 upper 0 below 1
    '{OP_RD,  8'h04, 32'h0, 32'h00000018, 8'd7},    // R7 bits 3 and 4
    '{OP_WR,  8'h04, 32'h0, 32'h0, 8'd8},
    '{OP_IRQ, 8'h00, 32'h0, 32'h0, 8'd8},           // R8 clear
    '{OP_WR,  8'h04, 32'h00000100, 32'h0, 8'd8},
    '{OP_IRQ, 8'h00, 32'h0, 32'h0, 8'd8},           // R8 bit 8 does not drive
    '{OP_RD,  8'h04, 32'h0, 32'h00000100, 8'd8},    // R8 full word stored
    '{OP_WR,  8'h04, 32'h00000080, 32'h0, 8'd8},
    '{OP_IRQ, 8'h00, 32'h0, 32'h1, 8'd8},           // R8 bit 7 drives
    '{OP_WR,  8'h04, 32'h0, 32'h0, 8'd8},
    '{OP_IRQ, 8'h00, 32'h0, 32'h0, 8'd8}            // R8
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic doRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual hung expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check(1, {31'b0, irqOut}, 32'h0); // R1 irq low after reset

    for (int i = 0; i < NVEC; i++) begin
      case (VECS[i].op)
        OP_WR: doWrite(VECS[i].addr, VECS[i].data);
        OP_RD: begin
          doRead(VECS[i].addr, rd);
          check(int'(VECS[i].req), rd, VECS[i].exp);
        end
        OP_IRQ: begin
          @(negedge clk);
          check(int'(VECS[i].req), {31'b0, irqOut}, VECS[i].exp);
        end
        default: begin
          @(negedge clk);
          check(int'(VECS[i].req), busRdData, VECS[i].exp);
        end
      endcase
    end

    // R11: strobe held four cycles on sample 5 steps it once
    @(negedge clk);
    busAddr = 8'h24; busRdEn = 1'b1;
    repeat (4) @(negedge clk);
    busRdEn = 1'b0;
    check(11, busRdData, 32'h0);           // R11 first value
    doRead(8'h24, rd);
    check(11, rd, 32'h00070005);           // R11 single step
    check(7, {31'b0, irqOut}, 32'h1);      // R7 5,7 above limit 0

    // R3: data changes only at the edge that samples the strobe
    @(negedge clk);
    busAddr = 8'h08; busRdEn = 1'b1;
    #5;
    check(3, busRdData, 32'h00070005);     // R3 before the edge
    @(negedge clk);
    busRdEn = 1'b0;
    check(3, busRdData, 32'h12345678);     // R3 after the edge

    // R1: reset in mid-run restores defaults
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    check(1, {31'b0, irqOut}, 32'h0);      // R1 irq cleared
    doRead(8'h08, rd);
    check(1, rd, 32'h0000000F);            // R1 detect default
    doRead(8'h24, rd);
    check(1, rd, 32'h0);                   // R1 sample cleared
    doRead(8'h04, rd);
    check(1, rd, 32'h0);                   // R1 irq control cleared

    finishRun();
  end

endmodule